// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit ports, called A and B, through a pair of storage registers and a multiplexer for each direction. Each port can be driven from the other port's live value or from the register that holds a stored copy of it. Each port can also be left undriven. Real tri-state pads do not exist inside a synchronous core. Each bus is therefore split into an external driver (value plus enable), an internal driver (value plus output enable) and a resolved bus value. A keeper holds the resolved value whenever nothing drives the bus.

The two capture strobes are asynchronous to the system clock. Each strobe goes through its own synchronizer. A detected rising edge copies the resolved bus into that direction's register. A copy is made whatever the select and enable inputs are. The output enables have opposite polarities: the B-side enable is active high and the A-side enable is active low. Enabling both sides in live mode creates a loop in which each bus holds its last value. Enabling both sides in stored mode swaps the two registers out onto the opposite buses.

Top module: `regxcvr_bridge`

## Requirements
- R1: A rising edge on `cap_a_async` copies the resolved A bus into `a_store_q` on the third rising clock edge after the strobe is first sampled high. This happens for every setting of the selects and enables.
- R2: A rising edge on `cap_b_async` copies the resolved B bus into `b_store_q` with the same three-edge latency. This also happens for every setting of the selects and enables.
- R3: Select encoding is 0 for live and 1 for stored. With `pick_ab`=0 the B driver carries the resolved A bus; with `pick_ab`=1 it carries `a_store_q`. `pick_ba` selects between the resolved B bus and `b_store_q` for the A driver in the same way.
- R4: `b_drv_oe` is high exactly when `b_side_en` is high. `a_drv_oe` is high exactly when `a_side_en_n` is low.
- R5: With `b_side_en`=0 and `a_side_en_n`=1 (isolation), neither port is driven by the block. Each bus shows its external value, or the kept value, and both registers still capture.
- R6: With both sides enabled and both selects at 1, the B bus shows `a_store_q` and the A bus shows `b_store_q` in the same cycle.
- R7: With both sides enabled, both selects at 0 and no external driver on either bus, each bus keeps the value it had in the previous cycle.
- R8: With A driven externally and passed live onto B, firing both strobes together leaves both registers holding the A value.
- R9: Toggling a select while the live and stored sources carry the same value leaves the driven output unchanged in every cycle.
- R10: Reset is synchronous and active low (`rst_n`). It clears both registers and both keepers to zero.
- R11: A bus that is driven neither externally nor internally holds the resolved value of the previous cycle.
- R12: The external driver and the block's driver are never enabled on the same port in the same cycle. This is an environment rule, and it is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_a_async | input | 1 | Asynchronous capture strobe for the A register |
| cap_b_async | input | 1 | Asynchronous capture strobe for the B register |
| pick_ab | input | 1 | Source for the B driver: 0 live A, 1 stored A |
| pick_ba | input | 1 | Source for the A driver: 0 live B, 1 stored B |
| b_side_en | input | 1 | Active-high enable for the B-side driver |
| a_side_en_n | input | 1 | Active-low enable for the A-side driver |
| a_ext_val | input | WIDTH | Value from the external A-side driver |
| a_ext_on | input | 1 | External A-side driver is active |
| b_ext_val | input | WIDTH | Value from the external B-side driver |
| b_ext_on | input | 1 | External B-side driver is active |
| a_drv_val | output | WIDTH | Value the block drives toward A |
| a_drv_oe | output | 1 | Block drives the A bus |
| b_drv_val | output | WIDTH | Value the block drives toward B |
| b_drv_oe | output | 1 | Block drives the B bus |
| a_bus | output | WIDTH | Resolved A bus value |
| b_bus | output | WIDTH | Resolved B bus value |
| a_store_q | output | WIDTH | Contents of the A register |
| b_store_q | output | WIDTH | Contents of the B register |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and a two-stage strobe synchronizer. With these values, every stimulus row can use distinct byte patterns that tell apart live data, stored data and kept data. Each row is held for four clock edges, which covers the three-edge capture latency. At this depth the bench can also check, cycle by cycle, the register swap between modes, the hold loop and the shared capture.

// File: rtl/regxcvr_pkg.sv
// Package: types shared by the transceiver modules.
// Assumes: nothing beyond IEEE 1800-2017.
package regxcvr_pkg;

    // Source choice of one direction's output multiplexer
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_pick_e;

    // Number of flops in a strobe synchronizer, including the edge-history flop
    function automatic int unsigned sync_depth(input int unsigned stages);
        return stages + 1;
    endfunction

endpackage

// File: rtl/regxcvr_edge_sync.sv
// Module: brings an asynchronous strobe into the clock domain through STAGES
// flops and emits a one-cycle pulse on each rising edge it detects.
// Assumes: the strobe stays high or low for at least one clock period.
module regxcvr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic rise_pulse
);
    import regxcvr_pkg::*;

    localparam int unsigned DEPTH = sync_depth(STAGES);

    logic [DEPTH-1:0] chain_q;

    // Shift the strobe along the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], strobe_async};
        end
    end

    // Rising edge: newest settled sample high, the one before it low
    always_comb begin
        rise_pulse = chain_q[DEPTH-2] & ~chain_q[DEPTH-1];
    end

endmodule

// File: rtl/regxcvr_glitchless_mux.sv
// Module: chooses between live and stored data for one direction. The
// AND-OR form adds the consensus term, so an output bit whose two sources
// agree holds steady while the select changes.
// Assumes: select is a single-bit level.
module regxcvr_glitchless_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  regxcvr_pkg::src_pick_e pick,
    input  logic [WIDTH-1:0]       live_val,
    input  logic [WIDTH-1:0]       stored_val,
    output logic [WIDTH-1:0]       out_val
);
    import regxcvr_pkg::*;

    logic [WIDTH-1:0] sel_vec;

    // Widen the select to the data width
    always_comb begin
        sel_vec = {WIDTH{pick == SRC_STORED}};
    end

    // One hazard-free sum-of-products cell per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign out_val[i] = (stored_val[i] & sel_vec[i])
                          | (live_val[i]   & ~sel_vec[i])
                          | (stored_val[i] & live_val[i]);
    end

endmodule

// File: rtl/regxcvr_lane.sv
// Module: one transfer direction. It holds the synchronized capture
// strobe, the storage register loaded from the source bus, and the output
// multiplexer that feeds the opposite port.
// Assumes: src_bus is the resolved value of the port being captured.
module regxcvr_lane #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_async,
    input  logic             pick_stored,
    input  logic [WIDTH-1:0] src_bus,
    output logic [WIDTH-1:0] store_q,
    output logic [WIDTH-1:0] drive_val
);
    import regxcvr_pkg::*;

    logic      load_pulse;
    src_pick_e pick;

    regxcvr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (strobe_async),
        .rise_pulse   (load_pulse)
    );

    // Load the register from the resolved source bus on a detected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (load_pulse) begin
            store_q <= src_bus;
        end
    end

    // Map the select level onto the source type
    always_comb begin
        pick = pick_stored ? SRC_STORED : SRC_LIVE;
    end

    regxcvr_glitchless_mux #(
        .WIDTH (WIDTH)
    ) u_mux (
        .pick       (pick),
        .live_val   (src_bus),
        .stored_val (store_q),
        .out_val    (drive_val)
    );

endmodule

// File: rtl/regxcvr_keeper.sv
// Module: bus-hold model for one port. It remembers the last resolved
// value and offers it while nothing drives the bus.
// Assumes: the resolved value is valid every clock.
module regxcvr_keeper #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_now,
    output logic [WIDTH-1:0] kept_q
);

    // Track the resolved bus every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q <= '0;
        end else begin
            kept_q <= bus_now;
        end
    end

endmodule

// File: rtl/regxcvr_bridge.sv
// Module: top of the registered bidirectional transceiver. Two lanes
// (A toward B, B toward A), two keepers, and the bus resolution.
// Bus priority: external driver, then internal driver, then keeper.
// When both internal drivers are live and nothing external drives, the
// live loop is broken at the keepers, so both buses hold.
// Assumes: external and internal drivers never share a port in a cycle.
module regxcvr_bridge #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_a_async,
    input  logic             cap_b_async,
    input  logic             pick_ab,
    input  logic             pick_ba,
    input  logic             b_side_en,
    input  logic             a_side_en_n,
    input  logic [WIDTH-1:0] a_ext_val,
    input  logic             a_ext_on,
    input  logic [WIDTH-1:0] b_ext_val,
    input  logic             b_ext_on,
    output logic [WIDTH-1:0] a_drv_val,
    output logic             a_drv_oe,
    output logic [WIDTH-1:0] b_drv_val,
    output logic             b_drv_oe,
    output logic [WIDTH-1:0] a_bus,
    output logic [WIDTH-1:0] b_bus,
    output logic [WIDTH-1:0] a_store_q,
    output logic [WIDTH-1:0] b_store_q
);

    logic [WIDTH-1:0] a_kept;
    logic [WIDTH-1:0] b_kept;
    logic [WIDTH-1:0] a_tail;
    logic [WIDTH-1:0] b_tail;

    // Enable polarities: B active high, A active low
    always_comb begin
        b_drv_oe = b_side_en;
        a_drv_oe = ~a_side_en_n;
    end

    // Value of each bus when the opposite bus's live path folds back onto it
    always_comb begin
        a_tail = a_ext_on ? a_ext_val
               : (a_drv_oe && pick_ba) ? b_store_q
               : a_kept;
        b_tail = b_ext_on ? b_ext_val
               : (b_drv_oe && pick_ab) ? a_store_q
               : b_kept;
    end

    // Resolve each bus without a combinational loop through the other port
    always_comb begin
        if (a_ext_on) begin
            a_bus = a_ext_val;
        end else if (a_drv_oe) begin
            if (pick_ba) begin
                a_bus = b_store_q;
            end else if (b_drv_oe && !pick_ab && !b_ext_on) begin
                a_bus = a_kept;
            end else begin
                a_bus = b_tail;
            end
        end else begin
            a_bus = a_kept;
        end

        if (b_ext_on) begin
            b_bus = b_ext_val;
        end else if (b_drv_oe) begin
            if (pick_ab) begin
                b_bus = a_store_q;
            end else if (a_drv_oe && !pick_ba && !a_ext_on) begin
                b_bus = b_kept;
            end else begin
                b_bus = a_tail;
            end
        end else begin
            b_bus = b_kept;
        end
    end

    regxcvr_lane #(
        .WIDTH       (WIDTH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_lane_ab (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (cap_a_async),
        .pick_stored  (pick_ab),
        .src_bus      (a_bus),
        .store_q      (a_store_q),
        .drive_val    (b_drv_val)
    );

    regxcvr_lane #(
        .WIDTH       (WIDTH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_lane_ba (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (cap_b_async),
        .pick_stored  (pick_ba),
        .src_bus      (b_bus),
        .store_q      (b_store_q),
        .drive_val    (a_drv_val)
    );

    regxcvr_keeper #(
        .WIDTH (WIDTH)
    ) u_keep_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_now (a_bus),
        .kept_q  (a_kept)
    );

    regxcvr_keeper #(
        .WIDTH (WIDTH)
    ) u_keep_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_now (b_bus),
        .kept_q  (b_kept)
    );

endmodule

// File: rtl/regxcvr_bridge_chk.sv
// Module: assertion checker for regxcvr_bridge, attached by bind.
// Assumes: it sees only the top-level ports.
module regxcvr_bridge_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pick_ab,
    input logic             pick_ba,
    input logic             b_side_en,
    input logic             a_side_en_n,
    input logic             a_ext_on,
    input logic             b_ext_on,
    input logic             a_drv_oe,
    input logic             b_drv_oe,
    input logic [WIDTH-1:0] a_bus,
    input logic [WIDTH-1:0] b_bus,
    input logic [WIDTH-1:0] a_store_q,
    input logic [WIDTH-1:0] b_store_q
);

    // R1
    a_reg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_store_q != $past(a_store_q)) |-> (a_store_q == $past(a_bus)));

    // R2
    b_reg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_store_q != $past(b_store_q)) |-> (b_store_q == $past(b_bus)));

    // R3
    b_stored_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv_oe && !b_ext_on && pick_ab) |-> (b_bus == a_store_q));

    // R3
    a_stored_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv_oe && !a_ext_on && pick_ba) |-> (a_bus == b_store_q));

    // R4
    enable_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv_oe == b_side_en) && (a_drv_oe != a_side_en_n));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (a_store_q == '0 && b_store_q == '0));

    // R11
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !a_ext_on && !a_drv_oe) |-> (a_bus == $past(a_bus)));

    // R11
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !b_ext_on && !b_drv_oe) |-> (b_bus == $past(b_bus)));

    // R12
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ext_on && a_drv_oe) && !(b_ext_on && b_drv_oe));

endmodule

bind regxcvr_bridge regxcvr_bridge_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_ab     (pick_ab),
    .pick_ba     (pick_ba),
    .b_side_en   (b_side_en),
    .a_side_en_n (a_side_en_n),
    .a_ext_on    (a_ext_on),
    .b_ext_on    (b_ext_on),
    .a_drv_oe    (a_drv_oe),
    .b_drv_oe    (b_drv_oe),
    .a_bus       (a_bus),
    .b_bus       (b_bus),
    .a_store_q   (a_store_q),
    .b_store_q   (b_store_q)
);

// File: tb/regxcvr_bridge_bench.sv
`timescale 1ns/1ps
module regxcvr_bridge_bench;

    localparam int W    = 8;
    localparam int ROWS = 10;

    // Row layout: ctrl[55:48] = {pick_ab, pick_ba, b_side_en, a_side_en_n,
    // a_ext_on, b_ext_on, cap_a, cap_b}, a_ext, b_ext, exp a_bus, exp b_bus,
    // exp a_store, exp b_store
    localparam logic [55:0] VEC [ROWS] = '{
        {8'b0001_1111, 8'h3C, 8'hA5, 8'h3C, 8'hA5, 8'h3C, 8'hA5}, // R5 isolation, both capture
        {8'b0011_1001, 8'h5A, 8'h00, 8'h5A, 8'h5A, 8'h3C, 8'h5A}, // R3 live A->B, R2 capture
        {8'b1011_1000, 8'h11, 8'h00, 8'h11, 8'h3C, 8'h3C, 8'h5A}, // R3 stored A->B
        {8'b0000_0110, 8'h00, 8'hC3, 8'hC3, 8'hC3, 8'hC3, 8'h5A}, // R3 live B->A, R1 capture
        {8'b0100_0100, 8'h00, 8'h77, 8'h5A, 8'h77, 8'hC3, 8'h5A}, // R3 stored B->A
        {8'b1110_0000, 8'h00, 8'h00, 8'h5A, 8'hC3, 8'hC3, 8'h5A}, // R6 swap stored
        {8'b0001_0000, 8'h00, 8'h00, 8'h5A, 8'hC3, 8'hC3, 8'h5A}, // R11 keepers
        {8'b0010_0011, 8'h00, 8'h00, 8'h5A, 8'hC3, 8'h5A, 8'hC3}, // R7 live loop holds
        {8'b0011_1011, 8'h96, 8'h00, 8'h96, 8'h96, 8'h96, 8'h96}, // R8 both hold A
        {8'b0001_1000, 8'h0F, 8'h00, 8'h0F, 8'h96, 8'h96, 8'h96}  // R11 B kept
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cap_a_async, cap_b_async, pick_ab, pick_ba;
    logic         b_side_en, a_side_en_n, a_ext_on, b_ext_on;
    logic [W-1:0] a_ext_val, b_ext_val;
    logic [W-1:0] a_drv_val, b_drv_val, a_bus, b_bus, a_store_q, b_store_q;
    logic         a_drv_oe, b_drv_oe;

    int tests_run = 0;
    int tests_failed = 0;

    always #4 clk = ~clk;

    regxcvr_bridge u_regxcvr_bridge (
        .clk(clk), .rst_n(rst_n), .cap_a_async(cap_a_async), .cap_b_async(cap_b_async),
        .pick_ab(pick_ab), .pick_ba(pick_ba), .b_side_en(b_side_en), .a_side_en_n(a_side_en_n),
        .a_ext_val(a_ext_val), .a_ext_on(a_ext_on), .b_ext_val(b_ext_val), .b_ext_on(b_ext_on),
        .a_drv_val(a_drv_val), .a_drv_oe(a_drv_oe), .b_drv_val(b_drv_val), .b_drv_oe(b_drv_oe),
        .a_bus(a_bus), .b_bus(b_bus), .a_store_q(a_store_q), .b_store_q(b_store_q)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [7:0] c, input logic [W-1:0] av, input logic [W-1:0] bv);
        {pick_ab, pick_ba, b_side_en, a_side_en_n, a_ext_on, b_ext_on, cap_a_async, cap_b_async} = c;
        a_ext_val = av;
        b_ext_val = bv;
    endtask

    initial begin : watchdog
        #(8 * 50000);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        set_ctrl(8'b0001_0000, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10", "a_store_q", a_store_q, 8'h00);
        check("R10", "b_store_q", b_store_q, 8'h00);
        check("R10", "a_bus", a_bus, 8'h00);
        check("R10", "b_bus", b_bus, 8'h00);
        check("R4", "idle oe", {6'b0, a_drv_oe, b_drv_oe}, 8'h00);

        // Vector table: each row held for four edges, strobes for the first one
        for (int r = 0; r < ROWS; r++) begin
            set_ctrl(VEC[r][55:48], VEC[r][47:40], VEC[r][39:32]);
            @(posedge clk);
            @(negedge clk);
            cap_a_async = 1'b0;
            cap_b_async = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R3/R5/R6/R7/R11", $sformatf("row %0d a_bus", r), a_bus, VEC[r][31:24]);
            check("R3/R5/R6/R7/R11", $sformatf("row %0d b_bus", r), b_bus, VEC[r][23:16]);
            check("R1/R8", $sformatf("row %0d a_store_q", r), a_store_q, VEC[r][15:8]);
            check("R2/R8", $sformatf("row %0d b_store_q", r), b_store_q, VEC[r][7:0]);
            check("R4", $sformatf("row %0d oe", r), {6'b0, a_drv_oe, b_drv_oe},
                  {6'b0, ~VEC[r][52], VEC[r][53]});
        end

        // R1 latency: after 2 edges not yet loaded, after the 3rd loaded
        set_ctrl(8'b0001_1010, 8'h42, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "before third edge", a_store_q, 8'h96);
        @(posedge clk);
        @(negedge clk);
        check("R1", "after third edge", a_store_q, 8'h42);
        cap_a_async = 1'b0;

        // R9: live A and stored A both 42, toggle select each cycle
        set_ctrl(8'b0011_1000, 8'h42, 8'h00);
        for (int k = 0; k < 6; k++) begin
            pick_ab = k[0];
            @(posedge clk);
            @(negedge clk);
            check("R9", $sformatf("toggle %0d b_drv_val", k), b_drv_val, 8'h42);
        end

        // R3: sources differ, select decides
        set_ctrl(8'b1011_1000, 8'h01, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check("R3", "stored b_drv_val", b_drv_val, 8'h42);
        pick_ab = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R3", "live b_drv_val", b_drv_val, 8'h01);

        // R10 mid-run reset clears registers and keepers
        set_ctrl(8'b0001_0000, '0, '0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10", "a_store_q after reset", a_store_q, 8'h00);
        check("R10", "b_store_q after reset", b_store_q, 8'h00);
        check("R10", "a_bus kept", a_bus, 8'h00);
        check("R10", "b_bus kept", b_bus, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule